// File: doc/BRIEF.md
# One-Hot Selected Register File with Masked Whole-Array Port

A small register file holding a parameterised number of narrow entries. Any number of narrow read and write ports pick their entry with a one-hot select vector, so no address decoder sits on the access path. A further whole-array port views every entry at once as one concatenated word. A per-entry enable mask chooses which slices that port reads or writes.

Every read path, narrow or whole, forwards the value being written in the same cycle. A read of an entry under write therefore returns the new value without a cycle of delay. When several writers hit one entry in a cycle, a fixed priority decides which value is kept.

The default build has 8 entries of 4 bits, 3 narrow read ports and 2 narrow write ports, giving a 32-bit whole-array word with 8 enables. Another useful build has 3 entries of 2 bits with 3 narrow readers and 3 narrow writers.

Top module: `onehot_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears every entry to zero.
- R2: A narrow write port whose select has exactly bit e set stores its data into entry e at the clock edge and leaves all other entries unchanged.
- R3: A narrow read port returns the entry whose select bit is set. An all-zero select returns zero.
- R4: A narrow write port with an all-zero select changes no entry.
- R5: A whole-array write stores slice e (bits e*WIDTH upward) into entry e only where enable bit e is set. Entries with a clear enable keep their value.
- R6: A whole-array read returns entry e in slice e where enable bit e is set, and zero in every slice whose enable is clear.
- R7: A narrow read of an entry being written in the same cycle returns the value that will be stored.
- R8: A whole-array read shows, in each enabled slice, the value that entry will store at the coming edge.
- R9: When two narrow write ports select one entry in a cycle, the higher-numbered port's data is stored.
- R10: A narrow write to an entry beats a whole-array write to the same entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel | input | RD_PORTS*ENTRIES | One-hot selects of the narrow read ports, port r at bits r*ENTRIES upward |
| rd_data | output | RD_PORTS*WIDTH | Narrow read data, port r at bits r*WIDTH upward |
| wr_sel | input | WR_PORTS*ENTRIES | One-hot selects of the narrow write ports, port w at bits w*ENTRIES upward |
| wr_data | input | WR_PORTS*WIDTH | Narrow write data, port w at bits w*WIDTH upward |
| all_rd_en | input | ENTRIES | Per-entry enable of the whole-array read |
| all_rd_data | output | ENTRIES*WIDTH | Whole-array read word, masked per entry |
| all_wr_en | input | ENTRIES | Per-entry enable of the whole-array write |
| all_wr_data | input | ENTRIES*WIDTH | Whole-array write word |

## Verification
The colliding functions are forwarding and write priority. A read can target an entry in the very cycle that two narrow writers, or a narrow writer and the whole-array port, all target it. The bench drives such a collision on the falling edge and samples the narrow and whole-array read outputs before the rising edge. These outputs must already show the winning value. After the edge, a whole-array read confirms that the same winner was stored and that untouched entries kept their old values.

// File: rtl/onehot_regfile.sv
module onehot_regfile #(
  parameter int ENTRIES  = 8,
  parameter int WIDTH    = 4,
  parameter int RD_PORTS = 3,
  parameter int WR_PORTS = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [RD_PORTS*ENTRIES-1:0] rd_sel,
  output logic [RD_PORTS*WIDTH-1:0]   rd_data,
  input  logic [WR_PORTS*ENTRIES-1:0] wr_sel,
  input  logic [WR_PORTS*WIDTH-1:0]   wr_data,
  input  logic [ENTRIES-1:0]          all_rd_en,
  output logic [ENTRIES*WIDTH-1:0]    all_rd_data,
  input  logic [ENTRIES-1:0]          all_wr_en,
  input  logic [ENTRIES*WIDTH-1:0]    all_wr_data
);
  localparam int BITS = ENTRIES * WIDTH;

  logic [BITS-1:0] q, nxt;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [WIDTH-1:0] nv;
    logic             hit;

    always_comb begin
      nv  = q[e*WIDTH +: WIDTH];
      hit = 1'b0;
      if (all_wr_en[e]) nv = all_wr_data[e*WIDTH +: WIDTH];
      for (int w = 0; w < WR_PORTS; w++) begin
        if (wr_sel[w*ENTRIES + e]) begin
          nv  = wr_data[w*WIDTH +: WIDTH];
          hit = 1'b1;
        end
      end
    end

    assign nxt[e*WIDTH +: WIDTH]         = nv;
    assign all_rd_data[e*WIDTH +: WIDTH] = all_rd_en[e] ? nv : '0;

    AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!hit && !all_wr_en[e]) |=> $stable(q[e*WIDTH +: WIDTH])); // R4
    AST_ALL_WR_LANDS: assert property (@(posedge clk) disable iff (rst)
      (all_wr_en[e] && !hit) |=> q[e*WIDTH +: WIDTH] == $past(all_wr_data[e*WIDTH +: WIDTH])); // R5
    AST_TOP_PORT_WINS: assert property (@(posedge clk) disable iff (rst)
      wr_sel[(WR_PORTS-1)*ENTRIES + e] |=> q[e*WIDTH +: WIDTH] == $past(wr_data[(WR_PORTS-1)*WIDTH +: WIDTH])); // R9
  end

  for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
    logic [WIDTH-1:0] acc;
    always_comb begin
      acc = '0;
      for (int e = 0; e < ENTRIES; e++)
        acc |= {WIDTH{rd_sel[r*ENTRIES + e]}} & nxt[e*WIDTH +: WIDTH];
    end
    assign rd_data[r*WIDTH +: WIDTH] = acc;

    AST_RD_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(rd_sel[r*ENTRIES +: ENTRIES])); // R3
  end

  for (genvar w = 0; w < WR_PORTS; w++) begin : g_wr
    AST_WR_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(wr_sel[w*ENTRIES +: ENTRIES])); // R2
  end

endmodule

// File: tb/onehot_regfile_test.sv
module onehot_regfile_test;
  logic        clk = 0;
  logic        rst;
  logic [23:0] rd_sel;
  logic [11:0] rd_data;
  logic [15:0] wr_sel;
  logic [7:0]  wr_data;
  logic [7:0]  all_rd_en, all_wr_en;
  logic [31:0] all_rd_data, all_wr_data;

  int checks = 0, errors = 0;
  logic [3:0] m [8];

  always #5 clk = ~clk;

  onehot_regfile uut (.clk, .rst, .rd_sel, .rd_data, .wr_sel, .wr_data,
                      .all_rd_en, .all_rd_data, .all_wr_en, .all_wr_data);

  function automatic logic [31:0] masked(input logic [7:0] en);
    logic [31:0] v = '0;
    for (int e = 0; e < 8; e++) if (en[e]) v[e*4 +: 4] = m[e];
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    rd_sel = '0; wr_sel = '0; wr_data = '0;
    all_rd_en = '0; all_wr_en = '0; all_wr_data = '0;
  endtask

  task automatic t_reset();
    @(negedge clk); idle(); all_wr_en = 8'hFF; all_wr_data = 32'hFFFF_FFFF;
    @(negedge clk); idle(); rst = 1;
    @(negedge clk); rst = 0; all_rd_en = 8'hFF; #1;
    for (int e = 0; e < 8; e++) m[e] = '0;
    chk("R1 reset clears all", all_rd_data, 32'h0);
  endtask

  task automatic t_narrow();
    @(negedge clk); idle(); wr_sel[3] = 1; wr_data[3:0] = 4'hA;
    @(negedge clk); idle(); m[3] = 4'hA;
    all_rd_en = 8'hFF; rd_sel[3] = 1; #1;
    chk("R2 only entry 3 written", all_rd_data, masked(8'hFF));
    chk("R3 read port0 entry 3", {28'h0, rd_data[3:0]}, 32'hA);
    chk("R3 zero select reads zero", {28'h0, rd_data[7:4]}, 32'h0);
  endtask

  task automatic t_zero_sel();
    @(negedge clk); idle(); wr_data = 8'hFF;
    @(negedge clk); idle(); all_rd_en = 8'hFF; #1;
    chk("R4 empty write select", all_rd_data, masked(8'hFF));
  endtask

  task automatic t_all_port();
    @(negedge clk); idle(); all_wr_en = 8'b0101_0101; all_wr_data = 32'h8765_4321;
    @(negedge clk); idle();
    for (int e = 0; e < 8; e += 2) m[e] = 4'(32'h8765_4321 >> (e*4));
    all_rd_en = 8'hFF; #1;
    chk("R5 masked whole write", all_rd_data, masked(8'hFF));
    all_rd_en = 8'hF0; #1;
    chk("R6 masked whole read upper", all_rd_data, masked(8'hF0));
    all_rd_en = 8'h00; #1;
    chk("R6 no enables reads zero", all_rd_data, 32'h0);
  endtask

  task automatic t_forward();
    @(negedge clk); idle();
    wr_sel[8+5] = 1; wr_data[7:4] = 4'h9;
    rd_sel[16+5] = 1; all_rd_en = 8'b0010_0001; #1;
    m[5] = 4'h9;
    chk("R7 narrow read forwards", {28'h0, rd_data[11:8]}, 32'h9);
    chk("R8 whole read forwards", all_rd_data, masked(8'b0010_0001));
    @(negedge clk); idle(); all_rd_en = 8'hFF; #1;
    chk("R7 forwarded value stored", all_rd_data, masked(8'hFF));
  endtask

  task automatic t_priority();
    @(negedge clk); idle();
    wr_sel[2] = 1; wr_sel[8+2] = 1; wr_data = 8'h21;
    rd_sel[2] = 1; #1;
    chk("R9 forward shows port1", {28'h0, rd_data[3:0]}, 32'h2);
    @(negedge clk); idle(); m[2] = 4'h2; all_rd_en = 8'hFF; #1;
    chk("R9 higher port stored", all_rd_data, masked(8'hFF));
    @(negedge clk); idle();
    wr_sel[7] = 1; wr_data[3:0] = 4'h4;
    all_wr_en = 8'b1000_0010; all_wr_data = 32'h7000_00B0;
    all_rd_en = 8'b1000_0010; #1;
    m[7] = 4'h4; m[1] = 4'hB;
    chk("R10 forward narrow over whole", all_rd_data, masked(8'b1000_0010));
    @(negedge clk); idle(); all_rd_en = 8'hFF; #1;
    chk("R10 narrow stored over whole", all_rd_data, masked(8'hFF));
  endtask

  initial begin
    idle(); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    t_reset();
    t_narrow();
    t_zero_sel();
    t_all_port();
    t_forward();
    t_priority();
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule